// File: doc/BRIEF.md
# Cycle-by-Cycle Overcurrent Protection Sequencer

This block sits between a PWM controller and the two gate drivers of a synchronous buck stage. It turns the controller's PWM command into a high-side enable and a low-side enable. Along the way it applies four protections. The first is a blanking window after each switch turns on. The second cuts the high-side pulse short the moment the peak-current comparator trips. The third drops a whole PWM pulse when the valley-current comparator is still tripped at the start of a new period. The fourth is a timed hiccup shutdown when either kind of fault repeats for too many periods in a row.

Peak faults and valley faults have separate consecutive-period counters. A period with no fault of a given kind sets that kind's counter back to zero. A peak fault also sets a lock. The lock keeps the high side off until the valley comparator has been seen clear after low-side blanking. A threshold-set select picks one of two pairs of comparator reference codes, and the block drives that pair out to the comparators.

Top module: `ocp_seq`

## Requirements
- R1: After reset both gate enables and the hiccup flag are 0. The block stays idle until it sees a genuine 0-to-1 transition of `pwm_in`. A PWM level that is held high through reset release does not start a pulse.
- R2: A PWM rising edge turns the high side on one clock later, with the low side off. A PWM falling edge turns the high side off and the low side on one clock later.
- R3: For the first `BLANK_CYC` (default 8) clock edges of high-side conduction, `hs_oc` is ignored.
- R4: Once high-side blanking has elapsed and `pwm_in` is still high, `hs_oc` = 1 turns the high side off and the low side on at the next clock. The high side stays off for the rest of that PWM pulse.
- R5: After a peak fault, a PWM rising edge is dropped whole while `ls_oc` has not yet been seen low after low-side blanking. The high side comes back only at a later rising edge.
- R6: If `ls_oc` = 1 at a PWM rising edge after low-side blanking has elapsed, that pulse is skipped. The low side stays on and the high side stays off until the next rising edge.
- R7: For the first `BLANK_CYC` clock edges of low-side conduction, `ls_oc` is ignored. A rising edge that arrives inside that window starts a normal pulse.
- R8: `FAULT_LIMIT` (default 15) consecutive periods with a peak fault enter hiccup at the clock of the last fault. A fault-free period in between clears the peak count.
- R9: `FAULT_LIMIT` consecutive skipped rising edges enter hiccup at the clock of the last skipped edge. This count is kept apart from the peak count, and a rising edge that is not skipped clears it.
- R10: In hiccup both gates are off and `hiccup` = 1 for exactly `HICCUP_CYC` clocks. The block then clears both counters, goes idle, and restarts on the next PWM rising edge.
- R11: `thr_sel` = 1 selects the strong set (`hs_ref` = 90, `ls_ref` = 73 by default). `thr_sel` = 0 selects the weak set (45 and 42). The outputs follow the select one clock later.
- R12: `hs_gate` and `ls_gate` are never both 1 in the same clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | PWM command from the controller |
| hs_oc | input | 1 | Peak (high-side) overcurrent comparator flag |
| ls_oc | input | 1 | Valley (low-side) overcurrent comparator flag |
| thr_sel | input | 1 | Threshold set select: 1 strong, 0 weak |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |
| hiccup | output | 1 | High while in hiccup shutdown |
| hs_ref | output | THR_W | Reference code for the peak comparator |
| ls_ref | output | THR_W | Reference code for the valley comparator |

## Verification
The properties assume that all inputs are synchronous to `clk`, and that `pwm_in` stays low longer than the low-side blanking window whenever a valley decision is expected. A peak-fault assertion also assumes `hs_oc` is only meaningful while the high side conducts. The directed stimulus changes every input on the falling clock edge. Off-times are 20 clocks except in the one scenario that deliberately lands a rising edge inside low-side blanking. Comparator flags are asserted only in the windows each scenario targets, and the hiccup length is shortened to 200 clocks so that repeated-fault runs stay short.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HS   = 2'd1,
    ST_LS   = 2'd2,
    ST_HIC  = 2'd3
  } ocp_state_e;

  // Consecutive-event count: an event advances (saturating), a clean period zeroes
  function automatic int unsigned consec_next(input int unsigned cur, input bit evt,
                                              input bit zero, input int unsigned lim);
    if (evt) return (cur < lim) ? cur + 1 : cur;
    if (zero) return 0;
    return cur;
  endfunction

  // Window counter step: hold at the limit once reached
  function automatic int unsigned window_step(input int unsigned cur, input int unsigned lim);
    return (cur < lim) ? cur + 1 : cur;
  endfunction

endpackage

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer #(
  parameter int BLANK_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on,
  output logic done
);
  import ocp_pkg::*;
  localparam int CW = $clog2(BLANK_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !on) cnt_q <= '0;
    else cnt_q <= CW'(window_step(32'(cnt_q), BLANK_CYC));
  end

  assign done = on && (cnt_q == CW'(BLANK_CYC));
endmodule

// File: rtl/ocp_fault_counter.sv
module ocp_fault_counter #(
  parameter int LIMIT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic zero,
  input  logic clr,
  output logic hit_next
);
  import ocp_pkg::*;
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else cnt_q <= CW'(consec_next(32'(cnt_q), evt, zero, LIMIT));
  end

  assign hit_next = evt && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/ocp_hiccup_timer.sv
module ocp_hiccup_timer #(
  parameter int LEN = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  import ocp_pkg::*;
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else cnt_q <= CW'(window_step(32'(cnt_q), LEN));
  end

  assign expire = run && (cnt_q == CW'(LEN - 1));
endmodule

// File: rtl/ocp_thr_select.sv
module ocp_thr_select #(
  parameter int THR_W = 8,
  parameter int HI_HS = 90,
  parameter int HI_LS = 73,
  parameter int LO_HS = 45,
  parameter int LO_LS = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  output logic [THR_W-1:0] hs_ref,
  output logic [THR_W-1:0] ls_ref
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_ref <= THR_W'(LO_HS);
      ls_ref <= THR_W'(LO_LS);
    end else begin
      hs_ref <= sel ? THR_W'(HI_HS) : THR_W'(LO_HS);
      ls_ref <= sel ? THR_W'(HI_LS) : THR_W'(LO_LS);
    end
  end
endmodule

// File: rtl/ocp_seq.sv
module ocp_seq #(
  parameter int BLANK_CYC   = 8,
  parameter int FAULT_LIMIT = 15,
  parameter int HICCUP_CYC  = 16384,
  parameter int THR_W       = 8,
  parameter int HI_HS       = 90,
  parameter int HI_LS       = 73,
  parameter int LO_HS       = 45,
  parameter int LO_LS       = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             hs_oc,
  input  logic             ls_oc,
  input  logic             thr_sel,
  output logic             hs_gate,
  output logic             ls_gate,
  output logic             hiccup,
  output logic [THR_W-1:0] hs_ref,
  output logic [THR_W-1:0] ls_ref
);
  import ocp_pkg::*;
  localparam int NSW = 2;  // index 0 high side, 1 low side

  ocp_state_e st_q, st_d;
  logic       pwm_q;
  logic       pwm_rise;
  logic [NSW-1:0] gate_on;
  logic [NSW-1:0] blank_done;
  logic       hs_blank_done, ls_blank_done;
  logic       peak_evt, skip_evt;
  logic       peak_lock_q, hs_seen_q;
  logic       hs_hit, ls_hit, go_hic, hic_expire;

  // Reset value 1: a level held high through reset is not an edge
  always_ff @(posedge clk) begin
    if (!rst_n) pwm_q <= 1'b1;
    else pwm_q <= pwm_in;
  end
  assign pwm_rise = pwm_in && !pwm_q;

  assign hs_gate = (st_q == ST_HS);
  assign ls_gate = (st_q == ST_LS);
  assign hiccup  = (st_q == ST_HIC);
  assign gate_on = {ls_gate, hs_gate};

  for (genvar g = 0; g < NSW; g++) begin : g_blank
    ocp_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
      .clk  (clk),
      .rst_n(rst_n),
      .on   (gate_on[g]),
      .done (blank_done[g])
    );
  end
  assign hs_blank_done = blank_done[0];
  assign ls_blank_done = blank_done[1];

  // Named protection events
  assign peak_evt = (st_q == ST_HS) && pwm_in && hs_blank_done && hs_oc;
  assign skip_evt = (st_q == ST_LS) && pwm_rise &&
                    ((ls_blank_done && ls_oc) || peak_lock_q);

  always_ff @(posedge clk) begin
    if (!rst_n || hic_expire) peak_lock_q <= 1'b0;
    else if (peak_evt) peak_lock_q <= 1'b1;
    else if ((st_q == ST_LS) && ls_blank_done && !ls_oc) peak_lock_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || hic_expire) hs_seen_q <= 1'b0;
    else if (peak_evt) hs_seen_q <= 1'b1;
    else if (pwm_rise) hs_seen_q <= 1'b0;
  end

  ocp_fault_counter #(.LIMIT(FAULT_LIMIT)) u_peak_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (peak_evt),
    .zero    (pwm_rise && !hs_seen_q && (st_q != ST_HIC)),
    .clr     (hic_expire),
    .hit_next(hs_hit)
  );

  ocp_fault_counter #(.LIMIT(FAULT_LIMIT)) u_valley_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (skip_evt),
    .zero    (pwm_rise && !skip_evt && (st_q != ST_HIC)),
    .clr     (hic_expire),
    .hit_next(ls_hit)
  );

  assign go_hic = hs_hit || ls_hit;

  ocp_hiccup_timer #(.LEN(HICCUP_CYC)) u_hic (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (st_q == ST_HIC),
    .expire(hic_expire)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (pwm_rise) st_d = ST_HS;
      ST_HS: begin
        if (go_hic) st_d = ST_HIC;
        else if (!pwm_in || peak_evt) st_d = ST_LS;
      end
      ST_LS: begin
        if (go_hic) st_d = ST_HIC;
        else if (pwm_rise && !skip_evt) st_d = ST_HS;
      end
      ST_HIC: if (hic_expire) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else st_q <= st_d;
  end

  ocp_thr_select #(
    .THR_W(THR_W), .HI_HS(HI_HS), .HI_LS(HI_LS), .LO_HS(LO_HS), .LO_LS(LO_LS)
  ) u_thr (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (thr_sel),
    .hs_ref(hs_ref),
    .ls_ref(ls_ref)
  );
endmodule

// File: rtl/ocp_seq_chk.sv
module ocp_seq_chk #(
  parameter int THR_W = 8,
  parameter int HI_HS = 90,
  parameter int HI_LS = 73
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_in,
  input logic             thr_sel,
  input logic             hs_gate,
  input logic             ls_gate,
  input logic             hiccup,
  input logic [THR_W-1:0] hs_ref,
  input logic [THR_W-1:0] ls_ref,
  input logic             peak_evt,
  input logic             skip_evt,
  input logic             hs_blank_done
);
  assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  assert_fall_hands_over_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate && !pwm_in) |=> (!hs_gate && ls_gate));

  assert_blank_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate && pwm_in && !hs_blank_done) |=> hs_gate);

  assert_peak_truncates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    peak_evt |=> (!hs_gate && (ls_gate || hiccup)));

  assert_skip_keeps_hs_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    skip_evt |=> !hs_gate);

  assert_hiccup_gates_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hiccup |-> (!hs_gate && !ls_gate));

  assert_hiccup_exit_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hiccup) |-> (!hs_gate && !ls_gate));

  assert_strong_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    thr_sel |=> (hs_ref == THR_W'(HI_HS) && ls_ref == THR_W'(HI_LS)));
endmodule

bind ocp_seq ocp_seq_chk #(.THR_W(THR_W), .HI_HS(HI_HS), .HI_LS(HI_LS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwm_in       (pwm_in),
  .thr_sel      (thr_sel),
  .hs_gate      (hs_gate),
  .ls_gate      (ls_gate),
  .hiccup       (hiccup),
  .hs_ref       (hs_ref),
  .ls_ref       (ls_ref),
  .peak_evt     (peak_evt),
  .skip_evt     (skip_evt),
  .hs_blank_done(hs_blank_done)
);

// File: tb/ocp_seq_test.sv
module ocp_seq_test;
  localparam int CLK_P   = 10;
  localparam int BLANK   = 8;
  localparam int LIMIT   = 15;
  localparam int HIC_LEN = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0, hs_oc = 1'b0, ls_oc = 1'b0, sel = 1'b0;
  logic hs_gate, ls_gate, hiccup;
  logic [7:0] hs_ref, ls_ref;
  int total = 0, bad = 0, overlap = 0;

  always #(CLK_P/2) clk = ~clk;

  ocp_seq #(.BLANK_CYC(BLANK), .FAULT_LIMIT(LIMIT), .HICCUP_CYC(HIC_LEN)) uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm), .hs_oc(hs_oc), .ls_oc(ls_oc),
    .thr_sel(sel), .hs_gate(hs_gate), .ls_gate(ls_gate), .hiccup(hiccup),
    .hs_ref(hs_ref), .ls_ref(ls_ref)
  );

  always @(negedge clk) if (rst_n && hs_gate && ls_gate) overlap++;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pwm_cycle(input int hi, input int lo);
    pwm = 1'b1; step(hi);
    pwm = 1'b0; step(lo);
  endtask

  // One period with a peak fault after blanking; returns hiccup seen after the fault
  task automatic fault_period(output bit hic);
    pwm = 1'b1; step(BLANK + 3);
    hs_oc = 1'b1; step(1);
    hic = hiccup;
    hs_oc = 1'b0;
    if (hic) begin pwm = 1'b0; return; end
    step(2);
    pwm = 1'b0; step(20);
  endtask

  // One period whose rising edge should be skipped; returns hs seen and hiccup seen
  task automatic skip_period(output bit hs_seen, output bit hic);
    pwm = 1'b1; step(1);
    hs_seen = hs_gate; hic = hiccup;
    if (hic) begin pwm = 1'b0; return; end
    step(9);
    pwm = 1'b0; step(20);
  endtask

  task automatic wait_hiccup_out(output int n);
    n = 0;
    while (hiccup && n < 100000) begin n++; step(1); end
  endtask

  task automatic t_reset;
    // R1: pwm held high across reset release must not start a pulse
    pwm = 1'b1; rst_n = 1'b0; step(3);
    rst_n = 1'b1; step(5);
    chk("R1 hs off after reset", hs_gate, 0);
    chk("R1 ls off after reset", ls_gate, 0);
    chk("R1 no hiccup after reset", hiccup, 0);
    pwm = 1'b0; step(3);
  endtask

  task automatic t_normal;
    pwm = 1'b1; step(1);
    chk("R2 hs on after rise", hs_gate, 1);
    chk("R2 ls off during pulse", ls_gate, 0);
    step(10);
    pwm = 1'b0; step(1);
    chk("R2 hs off after fall", hs_gate, 0);
    chk("R2 ls on after fall", ls_gate, 1);
    step(20);
  endtask

  task automatic t_hs_blank_and_peak;
    pwm = 1'b1; step(1);
    hs_oc = 1'b1; step(BLANK - 1);
    hs_oc = 1'b0;
    chk("R3 peak flag ignored in blanking", hs_gate, 1);
    step(2);
    hs_oc = 1'b1; step(1);
    chk("R4 hs cut on peak fault", hs_gate, 0);
    chk("R4 ls on after peak fault", ls_gate, 1);
    hs_oc = 1'b0; step(5);
    chk("R4 pulse stays truncated", hs_gate, 0);
    pwm = 1'b0; step(20);
    pwm_cycle(10, 20);  // clean period
  endtask

  task automatic t_peak_lock;
    bit hs_any = 1'b0;
    pwm = 1'b1; step(BLANK + 3);
    hs_oc = 1'b1; ls_oc = 1'b1; step(1);
    hs_oc = 1'b0; step(2);
    pwm = 1'b0; step(20);
    pwm = 1'b1; step(1);
    chk("R5 rise dropped under peak lock", hs_gate, 0);
    ls_oc = 1'b0; step(1);
    for (int i = 0; i < 8; i++) begin
      if (hs_gate) hs_any = 1'b1;
      step(1);
    end
    chk("R5 hs stays off for rest of pulse", hs_any, 0);
    pwm = 1'b0; step(20);
    pwm = 1'b1; step(1);
    chk("R5 hs resumes at later rise", hs_gate, 1);
    step(9);
    pwm = 1'b0; step(20);
  endtask

  task automatic t_valley_skip;
    pwm = 1'b1; step(10);
    pwm = 1'b0; step(12);
    ls_oc = 1'b1; step(8);
    pwm = 1'b1; step(1);
    chk("R6 valley fault skips pulse hs", hs_gate, 0);
    chk("R6 valley fault keeps ls on", ls_gate, 1);
    ls_oc = 1'b0; step(9);
    chk("R6 hs off for whole skipped pulse", hs_gate, 0);
    pwm = 1'b0; step(20);
    pwm = 1'b1; step(1);
    chk("R6 next rise proceeds", hs_gate, 1);
    step(9);
    pwm = 1'b0; step(20);
  endtask

  task automatic t_ls_blank;
    pwm = 1'b1; step(10);
    pwm = 1'b0; ls_oc = 1'b1; step(4);
    pwm = 1'b1; step(1);
    chk("R7 valley flag ignored in ls blanking", hs_gate, 1);
    ls_oc = 1'b0; step(9);
    pwm = 1'b0; step(20);
  endtask

  task automatic t_peak_count;
    bit hic, any;
    int n;
    any = 1'b0;
    for (int i = 0; i < LIMIT - 1; i++) begin fault_period(hic); any |= hic; end
    pwm_cycle(10, 20);
    for (int i = 0; i < LIMIT - 1; i++) begin fault_period(hic); any |= hic; end
    chk("R8 clean period clears peak count", any, 0);
    fault_period(hic);
    chk("R8 hiccup on last consecutive peak fault", hic, 1);
    chk("R10 hs off in hiccup", hs_gate, 0);
    chk("R10 ls off in hiccup", ls_gate, 0);
    wait_hiccup_out(n);
    chk("R10 hiccup length", n, HIC_LEN);
    step(2);
    chk("R10 idle after hiccup hs", hs_gate, 0);
    chk("R10 idle after hiccup ls", ls_gate, 0);
    pwm = 1'b1; step(1);
    chk("R10 restart on next rise", hs_gate, 1);
    step(9);
    pwm = 1'b0; step(20);
  endtask

  task automatic t_valley_count;
    bit hs_seen, hic, any_hs, any_hic;
    int n;
    any_hs = 1'b0; any_hic = 1'b0;
    ls_oc = 1'b1;
    for (int i = 0; i < 10; i++) begin
      skip_period(hs_seen, hic); any_hs |= hs_seen; any_hic |= hic;
    end
    ls_oc = 1'b0; step(1);
    pwm = 1'b1; step(1);
    chk("R9 clean rise proceeds", hs_gate, 1);
    step(9);
    pwm = 1'b0; step(20);
    ls_oc = 1'b1;
    for (int i = 0; i < LIMIT - 1; i++) begin
      skip_period(hs_seen, hic); any_hs |= hs_seen; any_hic |= hic;
    end
    chk("R9 skipped rises keep hs off", any_hs, 0);
    chk("R9 clean rise clears valley count", any_hic, 0);
    skip_period(hs_seen, hic);
    chk("R9 hiccup on last consecutive skip", hic, 1);
    ls_oc = 1'b0;
    wait_hiccup_out(n);
    chk("R10 hiccup length after valley run", n, HIC_LEN);
    step(3);
  endtask

  task automatic t_thr;
    sel = 1'b1; step(1);
    chk("R11 strong set hs ref", hs_ref, 90);
    chk("R11 strong set ls ref", ls_ref, 73);
    sel = 1'b0; step(1);
    chk("R11 weak set hs ref", hs_ref, 45);
    chk("R11 weak set ls ref", ls_ref, 42);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_hs_blank_and_peak();
    t_peak_lock();
    t_valley_skip();
    t_ls_blank();
    t_peak_count();
    t_valley_count();
    t_thr();
    chk("R12 gates never overlap", overlap, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule